// File: doc/BRIEF.md
# Pretrigger Ring-Buffer Capture Controller

This block runs a triggered acquisition for a group of ADC channels. Every accepted sample word (one 16-bit sample for each channel) is written without pause into a ring store. On a trigger the controller chooses a start point up to 2046 samples in the past. It then reads the store forward, packs sixteen consecutive samples of each channel into a 256-bit block and writes each block to memory at that channel's own block address. The event length is a block count. The addresses are loaded from per-channel start values when the acquisition is armed or started.

A host arms the controller and then waits for a trigger, or it starts an acquisition at once, or it aborts with a disable command. While armed, a trigger comes from the internal or the external trigger input, and each source has its own enable. Channels can be excluded from storage one by one. When the last block has been written the controller returns to idle. The working address of each channel can then be read as a block count.

The control FSM has three states. ST_IDLE means no acquisition. ST_ARMED means waiting for a trigger. ST_CAPTURE means blocks are being written. The transitions are:
- arm-accept: ST_IDLE to ST_ARMED on an arm command.
- start-accept: ST_IDLE to ST_CAPTURE on a start command.
- trigger-accept: ST_ARMED to ST_CAPTURE on an enabled trigger or a start command.
- abort: ST_ARMED or ST_CAPTURE to ST_IDLE on a disable command.
- complete: ST_CAPTURE to ST_IDLE after the final block.

Top module: `pretrig_capture`

## Requirements
- R1: After reset, stat_armed and stat_busy are 0, mem_we is 0, and every cur_addr field is 0.
- R2: In idle, an arm command (with no disable or start command in the same cycle) sets stat_armed=1 and stat_busy=1 in the next cycle. It also copies each channel's 24-bit field of cfg_start_addr (channel c at bits [24c+23:24c]) into that channel's cur_addr field.
- R3: While armed, trig_int with cfg_trig_int_en=1 or trig_ext with cfg_trig_ext_en=1 starts a capture: in the next cycle stat_armed=0 and stat_busy=1. A trigger from a source whose enable is 0, or any trigger while idle, changes nothing.
- R4: A start command from idle loads the start addresses and begins a capture at once with no pretrigger samples. The first stored sample is the one accepted in the start cycle or later. A start command while armed acts as a trigger.
- R5: A disable command returns the controller to idle (stat_armed=0, stat_busy=0) in the next cycle from any state. It takes priority over an arm or start command in the same cycle.
- R6: Let F be the number of samples accepted after the arm cycle and before the trigger cycle. The first stored sample lies min(P, F) samples before the first sample accepted in the trigger cycle or later, where P is the clamped pretrigger depth. Storage never starts earlier than the oldest sample accepted since arming.
- R7: A cfg_pre value of 2047 is treated as 2046 (the deepest legal pretrigger depth). Values 0 to 2046 are used as given.
- R8: Each capture writes cfg_len+1 blocks per enabled channel, read from cfg_len at the trigger. The order is block by block, and within a block channel 0 upward (mem_ch = channel index). Each write uses that channel's current block address, which then increments by one.
- R9: A channel whose cfg_ch_dis bit is 1 gets no memory writes, and its address stays at its start value.
- R10: After the final block write, stat_busy and stat_armed are 0, and each enabled channel's cur_addr equals its start address plus the number of blocks written.
- R11: Only samples with s_valid=1 are stored. Samples in a block are consecutive accepted samples, the earliest in mem_data bits [15:0] and sample j in bits [16j+15:16j].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_arm | input | 1 | Arm command pulse |
| cmd_start | input | 1 | Immediate-start command pulse |
| cmd_disable | input | 1 | Disable/abort command pulse |
| cfg_trig_int_en | input | 1 | Enable for the internal trigger |
| cfg_trig_ext_en | input | 1 | Enable for the external trigger |
| cfg_pre | input | 11 | Pretrigger depth in samples (0 to 2046; 2047 clamps) |
| cfg_len | input | 8 | Event length in blocks, minus one |
| cfg_ch_dis | input | NCH | Per-channel storage disable |
| cfg_start_addr | input | NCH*24 | Per-channel start block address |
| trig_int | input | 1 | Internal trigger |
| trig_ext | input | 1 | External trigger (already synchronised) |
| s_valid | input | 1 | Sample word valid |
| s_data | input | NCH*16 | One sample per channel, channel c at [16c+15:16c] |
| stat_armed | output | 1 | Waiting for trigger |
| stat_busy | output | 1 | Acquisition in progress (armed or capturing) |
| cur_addr | output | NCH*24 | Working block address per channel |
| mem_we | output | 1 | Block write strobe |
| mem_ch | output | 2 | Channel of the block being written |
| mem_addr | output | 24 | Block address of the write |
| mem_data | output | 256 | Sixteen packed samples |

## Verification
The capture path is tried with four input patterns:
- A long pretrigger window that has fully filled, which shows whether the start point is computed from the trigger position.
- A short arm-to-trigger wait with a deeper setting, which separates the fill limit from the configured depth.
- The start command, which must store no history at all.
- A gapped sample stream, which shows whether storage follows accepted samples rather than clock cycles.

Every sample value encodes its index and channel, so a block shifted by even one sample, or taken from the wrong channel, does not match. Triggers while idle, triggers from a disabled source and a disabled channel are each checked for the absence of writes and for unchanged addresses.

// File: rtl/pretrig_pkg.sv
package pretrig_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2
    } cap_state_e;
endpackage

// File: rtl/pretrig_ring.sv
module pretrig_ring #(
    parameter int NCH      = 4,
    parameter int SAMPLE_W = 16,
    parameter int RING_AW  = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s_valid,
    input  logic [NCH*SAMPLE_W-1:0] s_data,
    input  logic                    fill_clr,
    input  logic                    fill_en,
    input  logic [RING_AW-1:0]      rd_ptr,
    output logic [NCH*SAMPLE_W-1:0] rd_data,
    output logic [RING_AW-1:0]      wr_ptr,
    output logic [RING_AW-1:0]      fill
);
    localparam int DEPTH = 1 << RING_AW;
    localparam int WORD_W = NCH * SAMPLE_W;
    localparam logic [RING_AW-1:0] FILL_SAT = '1;

    logic [WORD_W-1:0] store_q [DEPTH];

    // sample store: written every accepted word, never paused
    always_ff @(posedge clk) begin
        if (s_valid) begin
            store_q[wr_ptr] <= s_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (s_valid) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    // number of words collected since arming, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || fill_clr) begin
            fill <= '0;
        end else if (fill_en && s_valid && fill != FILL_SAT) begin
            fill <= fill + 1'b1;
        end
    end

    assign rd_data = store_q[rd_ptr];
endmodule

// File: rtl/pretrig_ctrl.sv
module pretrig_ctrl
    import pretrig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_arm,
    input  logic cmd_start,
    input  logic cmd_disable,
    input  logic trig_hit,
    input  logic cap_done,
    output logic armed,
    output logic busy,
    output logic active,
    output logic load,
    output logic fire,
    output logic fire_nopre
);
    cap_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_disable)    state_d = ST_IDLE;
                else if (cmd_start) state_d = ST_CAPTURE;
                else if (cmd_arm)   state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (cmd_disable)                state_d = ST_IDLE;
                else if (cmd_start || trig_hit) state_d = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                if (cmd_disable || cap_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs: level flags and accept strobes
    always_comb begin
        armed      = 1'b0;
        busy       = 1'b0;
        active     = 1'b0;
        load       = 1'b0;
        fire       = 1'b0;
        fire_nopre = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!cmd_disable && (cmd_start || cmd_arm)) load = 1'b1;
                if (!cmd_disable && cmd_start) begin
                    fire       = 1'b1;
                    fire_nopre = 1'b1;
                end
            end
            ST_ARMED: begin
                armed = 1'b1;
                busy  = 1'b1;
                if (!cmd_disable && (cmd_start || trig_hit)) fire = 1'b1;
            end
            ST_CAPTURE: begin
                busy   = 1'b1;
                active = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pretrig_packer.sv
module pretrig_packer #(
    parameter int NCH         = 4,
    parameter int SAMPLE_W    = 16,
    parameter int BLK_SAMPLES = 16,
    parameter int RING_AW     = 11,
    parameter int LEN_W       = 8,
    parameter int CH_W        = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            active,
    input  logic                            fire,
    input  logic                            fire_nopre,
    input  logic [RING_AW-1:0]              wr_ptr,
    input  logic [RING_AW-1:0]              fill,
    input  logic [RING_AW-1:0]              cfg_pre,
    input  logic [LEN_W-1:0]                cfg_len,
    input  logic [NCH-1:0]                  ch_dis,
    input  logic [NCH*SAMPLE_W-1:0]         rd_data,
    output logic [RING_AW-1:0]              rd_ptr,
    output logic                            we_o,
    output logic [CH_W-1:0]                 ch_o,
    output logic [SAMPLE_W*BLK_SAMPLES-1:0] data_o,
    output logic                            done_o
);
    localparam int BLK_W   = SAMPLE_W * BLK_SAMPLES;
    localparam int K_W     = $clog2(BLK_SAMPLES);
    localparam int CNT_W   = LEN_W + 1;
    localparam int PRE_MAX = (1 << RING_AW) - 2;
    localparam logic [K_W-1:0]  K_LAST  = K_W'(BLK_SAMPLES - 1);
    localparam logic [CH_W-1:0] CH_LAST = CH_W'(NCH - 1);

    logic [RING_AW-1:0] pre_clamp, pre_eff;
    logic [K_W-1:0]     k_q;
    logic [CNT_W-1:0]   asm_blk_q, blk_done_q, total;
    logic [LEN_W-1:0]   len_q;
    logic               emit_busy_q;
    logic [CH_W-1:0]    emit_ch_q;
    logic               rd_en, blk_full, emit_last;
    logic [NCH*BLK_W-1:0] hold_flat;

    // start point: clamp to the legal depth, then to what has been collected
    always_comb begin
        if (32'(cfg_pre) > PRE_MAX) pre_clamp = RING_AW'(PRE_MAX);
        else                        pre_clamp = cfg_pre;
        if (fire_nopre)             pre_eff = '0;
        else if (fill < pre_clamp)  pre_eff = fill;
        else                        pre_eff = pre_clamp;
    end

    assign total     = {1'b0, len_q} + 1'b1;
    assign rd_en     = active && (rd_ptr != wr_ptr) && (asm_blk_q != total);
    assign blk_full  = rd_en && (k_q == K_LAST);
    assign emit_last = active && emit_busy_q && (emit_ch_q == CH_LAST);
    assign done_o    = emit_last && (blk_done_q == {1'b0, len_q});
    assign we_o      = active && emit_busy_q && !ch_dis[emit_ch_q];
    assign ch_o      = emit_ch_q;
    assign data_o    = hold_flat[32'(emit_ch_q)*BLK_W +: BLK_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr      <= '0;
            k_q         <= '0;
            asm_blk_q   <= '0;
            blk_done_q  <= '0;
            len_q       <= '0;
            emit_busy_q <= 1'b0;
            emit_ch_q   <= '0;
        end else if (fire) begin
            rd_ptr      <= wr_ptr - pre_eff;
            k_q         <= '0;
            asm_blk_q   <= '0;
            blk_done_q  <= '0;
            len_q       <= cfg_len;
            emit_busy_q <= 1'b0;
            emit_ch_q   <= '0;
        end else if (active) begin
            if (rd_en) begin
                rd_ptr <= rd_ptr + 1'b1;
                k_q    <= (k_q == K_LAST) ? '0 : k_q + 1'b1;
                if (k_q == K_LAST) asm_blk_q <= asm_blk_q + 1'b1;
            end
            if (emit_busy_q) begin
                if (emit_ch_q == CH_LAST) begin
                    emit_ch_q   <= '0;
                    emit_busy_q <= 1'b0;
                    blk_done_q  <= blk_done_q + 1'b1;
                end else begin
                    emit_ch_q <= emit_ch_q + 1'b1;
                end
            end
            // a freshly completed block wins over the end of the previous one
            if (blk_full) emit_busy_q <= 1'b1;
        end
    end

    // per-channel assembly and hold registers
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [SAMPLE_W-1:0] part_q [BLK_SAMPLES-1];
        logic [BLK_W-1:0]    blk_c;
        logic [BLK_W-1:0]    hold_q;
        logic [SAMPLE_W-1:0] smp;

        assign smp = rd_data[c*SAMPLE_W +: SAMPLE_W];

        always_comb begin
            for (int j = 0; j < BLK_SAMPLES - 1; j++) begin
                blk_c[j*SAMPLE_W +: SAMPLE_W] = part_q[j];
            end
            blk_c[BLK_W-1 -: SAMPLE_W] = smp;
        end

        always_ff @(posedge clk) begin
            if (rd_en) begin
                if (k_q != K_LAST) part_q[k_q] <= smp;
                else               hold_q      <= blk_c;
            end
        end

        assign hold_flat[c*BLK_W +: BLK_W] = hold_q;
    end
endmodule

// File: rtl/pretrig_addr.sv
module pretrig_addr #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 24,
    parameter int CH_W   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [NCH*ADDR_W-1:0] start_flat,
    input  logic                  inc,
    input  logic [CH_W-1:0]       inc_ch,
    output logic [NCH*ADDR_W-1:0] addr_flat
);
    for (genvar c = 0; c < NCH; c++) begin : g_addr
        logic [ADDR_W-1:0] addr_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q <= '0;
            end else if (load) begin
                addr_q <= start_flat[c*ADDR_W +: ADDR_W];
            end else if (inc && inc_ch == CH_W'(c)) begin
                addr_q <= addr_q + 1'b1;
            end
        end
        assign addr_flat[c*ADDR_W +: ADDR_W] = addr_q;
    end
endmodule

// File: rtl/pretrig_capture.sv
module pretrig_capture #(
    parameter int NCH         = 4,
    parameter int SAMPLE_W    = 16,
    parameter int BLK_SAMPLES = 16,
    parameter int RING_AW     = 11,
    parameter int LEN_W       = 8,
    parameter int ADDR_W      = 24,
    localparam int BLK_W      = SAMPLE_W * BLK_SAMPLES,
    localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_arm,
    input  logic                    cmd_start,
    input  logic                    cmd_disable,
    input  logic                    cfg_trig_int_en,
    input  logic                    cfg_trig_ext_en,
    input  logic [RING_AW-1:0]      cfg_pre,
    input  logic [LEN_W-1:0]        cfg_len,
    input  logic [NCH-1:0]          cfg_ch_dis,
    input  logic [NCH*ADDR_W-1:0]   cfg_start_addr,
    input  logic                    trig_int,
    input  logic                    trig_ext,
    input  logic                    s_valid,
    input  logic [NCH*SAMPLE_W-1:0] s_data,
    output logic                    stat_armed,
    output logic                    stat_busy,
    output logic [NCH*ADDR_W-1:0]   cur_addr,
    output logic                    mem_we,
    output logic [CH_W-1:0]         mem_ch,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [BLK_W-1:0]        mem_data
);
    logic trig_hit, cap_done, active, load, fire, fire_nopre;
    logic [RING_AW-1:0] wr_ptr, rd_ptr, fill;
    logic [NCH*SAMPLE_W-1:0] rd_data;

    assign trig_hit = (trig_int && cfg_trig_int_en) || (trig_ext && cfg_trig_ext_en);

    pretrig_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_arm    (cmd_arm),
        .cmd_start  (cmd_start),
        .cmd_disable(cmd_disable),
        .trig_hit   (trig_hit),
        .cap_done   (cap_done),
        .armed      (stat_armed),
        .busy       (stat_busy),
        .active     (active),
        .load       (load),
        .fire       (fire),
        .fire_nopre (fire_nopre)
    );

    pretrig_ring #(.NCH(NCH), .SAMPLE_W(SAMPLE_W), .RING_AW(RING_AW)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (s_valid),
        .s_data  (s_data),
        .fill_clr(load),
        .fill_en (stat_armed),
        .rd_ptr  (rd_ptr),
        .rd_data (rd_data),
        .wr_ptr  (wr_ptr),
        .fill    (fill)
    );

    pretrig_packer #(
        .NCH(NCH), .SAMPLE_W(SAMPLE_W), .BLK_SAMPLES(BLK_SAMPLES),
        .RING_AW(RING_AW), .LEN_W(LEN_W), .CH_W(CH_W)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .fire      (fire),
        .fire_nopre(fire_nopre),
        .wr_ptr    (wr_ptr),
        .fill      (fill),
        .cfg_pre   (cfg_pre),
        .cfg_len   (cfg_len),
        .ch_dis    (cfg_ch_dis),
        .rd_data   (rd_data),
        .rd_ptr    (rd_ptr),
        .we_o      (mem_we),
        .ch_o      (mem_ch),
        .data_o    (mem_data),
        .done_o    (cap_done)
    );

    pretrig_addr #(.NCH(NCH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .start_flat(cfg_start_addr),
        .inc       (mem_we),
        .inc_ch    (mem_ch),
        .addr_flat (cur_addr)
    );

    assign mem_addr = cur_addr[32'(mem_ch)*ADDR_W +: ADDR_W];
endmodule

// File: rtl/pretrig_capture_chk.sv
module pretrig_capture_chk #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_arm,
    input logic            cmd_start,
    input logic            cmd_disable,
    input logic            stat_armed,
    input logic            stat_busy,
    input logic            mem_we,
    input logic [CH_W-1:0] mem_ch,
    input logic [NCH-1:0]  cfg_ch_dis
);
    // R5
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_disable |=> (!stat_busy && !stat_armed));

    // R2
    arm_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_arm && !cmd_start && !cmd_disable && !stat_busy) |=> (stat_armed && stat_busy));

    // R4
    start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !cmd_disable && (!stat_busy || stat_armed)) |=> (stat_busy && !stat_armed));

    // R3
    idle_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_busy && !cmd_arm && !cmd_start) |=> !stat_busy);

    // R8
    write_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (stat_busy && !stat_armed));

    // R9
    dis_ch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !cfg_ch_dis[mem_ch]);
endmodule

bind pretrig_capture pretrig_capture_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_arm    (cmd_arm),
    .cmd_start  (cmd_start),
    .cmd_disable(cmd_disable),
    .stat_armed (stat_armed),
    .stat_busy  (stat_busy),
    .mem_we     (mem_we),
    .mem_ch     (mem_ch),
    .cfg_ch_dis (cfg_ch_dis)
);

// File: tb/pretrig_capture_test.sv
`timescale 1ns/1ps
module pretrig_capture_test;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_arm = 0, cmd_start = 0, cmd_disable = 0;
    logic cfg_trig_int_en = 1, cfg_trig_ext_en = 1;
    logic [10:0] cfg_pre = '0;
    logic [7:0]  cfg_len = '0;
    logic [NCH-1:0] cfg_ch_dis = '0;
    logic [NCH*24-1:0] cfg_start_addr;
    logic trig_int = 0, trig_ext = 0;
    logic s_valid = 0;
    logic [NCH*16-1:0] s_data = '0;
    logic stat_armed, stat_busy, mem_we;
    logic [NCH*24-1:0] cur_addr;
    logic [1:0] mem_ch;
    logic [23:0] mem_addr;
    logic [255:0] mem_data;

    pretrig_capture uut (.*);

    always #10 clk = ~clk;

    int total = 0, bad = 0;
    int nidx = 0, cyc = 0, arm_after = 0;
    bit gap = 0;
    logic [23:0] st_addr [NCH];
    logic [23:0] st_lat  [NCH];
    int          nblk_last = 0;
    logic [287:0] exp_q [$];

    always_comb for (int c = 0; c < NCH; c++) cfg_start_addr[c*24 +: 24] = st_addr[c];

    function automatic logic [15:0] smp(int n, int c);
        return 16'(n * 37 + c * 4099 + 5);
    endfunction

    function automatic logic [255:0] blk(int first, int c);
        logic [255:0] b;
        for (int j = 0; j < 16; j++) b[16*j +: 16] = smp(first + j, c);
        return b;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // sample driver: index advances only for accepted words
    always @(posedge clk) begin
        if (rst_n && s_valid) nidx++;
        cyc++;
        #2;
        s_valid = rst_n && (!gap || (cyc % 3 != 0));
        for (int c = 0; c < NCH; c++) s_data[16*c +: 16] = smp(nidx, c);
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                chk(0, "R8 unexpected write", {246'd0, mem_ch, mem_addr}, 256'd0);
            end else begin
                logic [287:0] it;
                it = exp_q.pop_front();
                chk(mem_ch == it[281:280], "R8 channel order", 256'(mem_ch), 256'(it[281:280]));
                chk(mem_addr == it[279:256], "R8 block address", 256'(mem_addr), 256'(it[279:256]));
                chk(mem_data == it[255:0], "R6/R11 block data", mem_data, it[255:0]);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_arm();
        @(negedge clk); cmd_arm = 1;
        @(negedge clk); cmd_arm = 0;
        arm_after = nidx;
        for (int c = 0; c < NCH; c++) st_lat[c] = st_addr[c];
    endtask

    task automatic push_cap(int first, int nblk);
        nblk_last = nblk;
        for (int b = 0; b < nblk; b++)
            for (int c = 0; c < NCH; c++)
                if (!cfg_ch_dis[c]) exp_q.push_back({6'd0, 2'(c), 24'(st_lat[c] + 24'(b)), blk(first + 16*b, c)});
    endtask

    task automatic do_trig(bit ext);
        int t, f, pc, pe;
        @(negedge clk);
        t  = nidx;
        f  = t - arm_after;
        pc = (cfg_pre > 11'd2046) ? 2046 : int'(cfg_pre);
        pe = (f < pc) ? f : pc;
        push_cap(t - pe, int'(cfg_len) + 1);
        if (ext) trig_ext = 1; else trig_int = 1;
        @(negedge clk);
        trig_ext = 0; trig_int = 0;
        chk(!stat_armed && stat_busy, "R3 trigger accepted", 256'({stat_armed, stat_busy}), 256'b01);
    endtask

    task automatic wait_done(string tag);
        int n = 0;
        while (stat_busy && n < 20000) begin @(negedge clk); n++; end
        chk(!stat_busy && !stat_armed, {tag, " R10 idle after capture"}, 256'({stat_armed, stat_busy}), 256'b00);
        chk(exp_q.size() == 0, {tag, " R8 all blocks written"}, 256'(exp_q.size()), 256'd0);
        for (int c = 0; c < NCH; c++) begin
            logic [23:0] e;
            e = cfg_ch_dis[c] ? st_lat[c] : st_lat[c] + 24'(nblk_last);
            chk(cur_addr[24*c +: 24] == e, {tag, cfg_ch_dis[c] ? " R9 address held" : " R10 final address"},
                256'(cur_addr[24*c +: 24]), 256'(e));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 256'd0, 256'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) st_addr[c] = 24'h1000 * 24'(c + 1);
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!stat_armed && !stat_busy && !mem_we, "R1 reset flags",
            256'({stat_armed, stat_busy, mem_we}), 256'd0);
        chk(cur_addr == '0, "R1 reset address", 256'(cur_addr), 256'd0);

        // A: full pretrigger window, internal trigger
        cfg_pre = 11'd40; cfg_len = 8'd2;
        do_arm();
        chk(stat_armed && stat_busy, "R2 armed flags", 256'({stat_armed, stat_busy}), 256'b11);
        chk(cur_addr[24 +: 24] == st_addr[1], "R2 start address loaded", 256'(cur_addr[24 +: 24]), 256'(st_addr[1]));
        idle(100);
        do_trig(0);
        wait_done("A");

        // B: trigger while idle is ignored (R3)
        @(negedge clk); trig_int = 1; trig_ext = 1;
        @(negedge clk); trig_int = 0; trig_ext = 0;
        idle(40);
        chk(!stat_busy, "R3 idle trigger ignored", 256'(stat_busy), 256'd0);
        chk(cur_addr[0 +: 24] == st_lat[0] + 24'd3, "R3 idle address unchanged", 256'(cur_addr[0 +: 24]), 256'(st_lat[0] + 24'd3));

        // C: disabled source ignored, then short fill with deep setting (R6)
        cfg_trig_ext_en = 0; cfg_pre = 11'd100; cfg_len = 8'd1;
        for (int c = 0; c < NCH; c++) st_addr[c] = 24'h20000 + 24'(c * 64);
        do_arm();
        idle(20);
        @(negedge clk); trig_ext = 1;
        @(negedge clk); trig_ext = 0;
        idle(3);
        chk(stat_armed, "R3 disabled source ignored", 256'(stat_armed), 256'd1);
        do_trig(0);
        wait_done("C");
        cfg_trig_ext_en = 1;

        // D: immediate start carries no history (R4)
        cfg_pre = 11'd50; cfg_len = 8'd0;
        for (int c = 0; c < NCH; c++) st_addr[c] = 24'hFFFFFF - 24'(c);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) st_lat[c] = st_addr[c];
        push_cap(nidx, 1);
        cmd_start = 1;
        @(negedge clk); cmd_start = 0;
        chk(stat_busy && !stat_armed, "R4 start runs", 256'({stat_armed, stat_busy}), 256'b01);
        wait_done("D R4");

        // E: disable while armed, and disable beats arm (R5)
        do_arm();
        idle(5);
        @(negedge clk); cmd_disable = 1;
        @(negedge clk); cmd_disable = 0;
        chk(!stat_armed && !stat_busy, "R5 disable from armed", 256'({stat_armed, stat_busy}), 256'd0);
        @(negedge clk); trig_int = 1;
        @(negedge clk); trig_int = 0;
        idle(40);
        chk(!stat_busy, "R5 trigger after disable ignored", 256'(stat_busy), 256'd0);
        @(negedge clk); cmd_disable = 1; cmd_arm = 1;
        @(negedge clk); cmd_disable = 0; cmd_arm = 0;
        chk(!stat_armed, "R5 disable over arm", 256'(stat_armed), 256'd0);

        // F: depth clamp 2047 -> 2046 with a disabled channel (R7, R9)
        cfg_pre = 11'd2047; cfg_len = 8'd0; cfg_ch_dis = 4'b0100;
        for (int c = 0; c < NCH; c++) st_addr[c] = 24'h300 + 24'(c * 16);
        do_arm();
        idle(2100);
        do_trig(1);
        wait_done("F R7");
        cfg_ch_dis = '0;

        // G: gapped stream, only accepted words are stored (R11)
        gap = 1; cfg_pre = 11'd20; cfg_len = 8'd3;
        for (int c = 0; c < NCH; c++) st_addr[c] = 24'h4000 + 24'(c);
        do_arm();
        idle(60);
        do_trig(0);
        wait_done("G R11");
        gap = 0;

        idle(5);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule